// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer driven through one 8-bit control register. Writes that match reserved byte values act as commands. One restarts the watchdog and clears its count. A pair of bytes, if the second arrives soon enough after the first, switches it off. A further byte blocks that switch-off path until the next reset. Any write with the top bit clear programs a 3-bit interval. The interval selects a timeout of 4^(3+interval) clock cycles.

While the watchdog is running and software stops reloading it, the count reaches the end of its interval. The block then raises a reset request for one clock and sets a sticky flag that records the watchdog as the cause. A system reset (`rst_n`) returns the control state to its defaults but leaves the flag in place. Only the power-on reset (`porRst_n`) clears the flag. The read port always shows the running status and the programmed interval.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is running with interval 7, `rdData` reads 0x17, and `rstReq` is low.
- R2: A write of 0xA5 starts the watchdog and restarts its count. `rstReq` rises exactly 4^(3+interval) clocks after the edge that takes the write, so 64 clocks for interval 0 and 256 for interval 1.
- R3: A write of 0xDE followed by 0xAD at most 4 clocks later stops the watchdog. If the 0xAD comes 5 or more clocks after the 0xDE, it has no effect.
- R4: A write of 0xFF blocks the stop sequence until the next reset. While blocked, 0xDE/0xAD leaves the watchdog running, and 0xA5 still restarts the count.
- R5: A write with bit 7 equal to 0 loads bits 2:0 into the interval. A write with bit 7 equal to 1 never changes the interval, and a non-command value with bit 7 set changes nothing.
- R6: `rdData` bit 4 is 1 when the watchdog is running. Bits 2:0 hold the interval, and all other bits read 0.
- R7: On timeout `rstReq` is high for exactly one clock. The count restarts at zero, so pulses repeat every period while the watchdog runs.
- R8: While the watchdog is stopped, `rstReq` stays low.
- R9: `wdtFlag` is set on the clock where `rstReq` rises. It survives `rst_n` and is cleared only by `porRst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset; does not clear `wdtFlag` |
| porRst_n | input | 1 | Synchronous active-low power-on reset; clears all state, including `wdtFlag` |
| wrEn | input | 1 | Write strobe for the control register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read value: bit 4 is the running status, bits 2:0 are the interval |
| rstReq | output | 1 | One-clock reset request on timeout |
| wdtFlag | output | 1 | Sticky flag recording a watchdog timeout |

## Verification
The bench places the second key byte at the last clock that still counts and at the first clock that does not. A window that is one clock too short or too long shows up as the wrong running status. Timeout pulses are sampled at the exact period and one clock before it, for two intervals and again after a mid-period reload. An off-by-one in the count limit, or a reload that does not clear the count, moves the pulse. The lock is checked for blocking the stop sequence while still accepting reloads, and for being cleared by reset. The flag is checked across a system reset and a power-on reset, which catches a flag tied to the wrong reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Command byte values
  localparam logic [7:0] KEY_RUN  = 8'hA5;
  localparam logic [7:0] KEY_ARM  = 8'hDE;
  localparam logic [7:0] KEY_OFF  = 8'hAD;
  localparam logic [7:0] KEY_LOCK = 8'hFF;

  // Strobes from control to datapath
  typedef struct packed {
    logic reload;
    logic run;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int INT_W   = 3,
  parameter int WIN     = 4,
  parameter int DEF_INT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  output wdtStrobe_t       strobe,
  output logic [INT_W-1:0] interval,
  output logic             lockState
);
  localparam int WIN_W = $clog2(WIN + 1);

  logic             active;
  logic [WIN_W-1:0] winCnt;
  logic isRun, isArm, isOff, isLock, isCfg;

  always_comb begin
    isRun  = wrEn && (wrData == KEY_RUN);
    isArm  = wrEn && (wrData == KEY_ARM);
    isOff  = wrEn && (wrData == KEY_OFF);
    isLock = wrEn && (wrData == KEY_LOCK);
    isCfg  = wrEn && !wrData[7];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b1;
      lockState <= 1'b0;
      winCnt    <= '0;
      interval  <= INT_W'(DEF_INT);
    end else begin
      if (isRun)
        active <= 1'b1;
      else if (isOff && (winCnt != '0) && !lockState)
        active <= 1'b0;

      if (isLock)
        lockState <= 1'b1;

      // window counts the clocks left for the second key byte
      if (isArm)
        winCnt <= WIN_W'(WIN);
      else if (winCnt != '0)
        winCnt <= winCnt - 1'b1;

      if (isCfg)
        interval <= wrData[INT_W-1:0];
    end
  end

  assign strobe.reload = isRun;
  assign strobe.run    = active;
endmodule

// File: rtl/wdt_dpath.sv
module wdt_dpath
  import wdt_pkg::*;
#(
  parameter int INT_W     = 3,
  parameter int BASE_LOG4 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             porRst_n,
  input  wdtStrobe_t       strobe,
  input  logic [INT_W-1:0] interval,
  output logic             rstReq,
  output logic             wdtFlag
);
  localparam int MAX_INT = (1 << INT_W) - 1;
  localparam int CNT_W   = 2 * (BASE_LOG4 + MAX_INT);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastVal;
  logic             fire;

  always_comb begin
    lastVal = {CNT_W{1'b1}} >> (CNT_W - 2 * (BASE_LOG4 + int'(interval)));
    fire    = strobe.run && !strobe.reload && (count >= lastVal);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= fire;
      if (strobe.reload || !strobe.run || fire)
        count <= '0;
      else
        count <= count + 1'b1;
    end
  end

  // flag only cleared by power-on reset
  always_ff @(posedge clk) begin
    if (!porRst_n)
      wdtFlag <= 1'b0;
    else if (rst_n && fire)
      wdtFlag <= 1'b1;
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int INT_W     = 3,
  parameter int WIN       = 4,
  parameter int DEF_INT   = 7,
  parameter int BASE_LOG4 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       porRst_n,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       rstReq,
  output logic       wdtFlag
);
  localparam int STATUS_BIT = 4;

  wdtStrobe_t       strobe;
  logic [INT_W-1:0] interval;
  logic             lockState;
  logic             sysRst_n;

  assign sysRst_n = rst_n & porRst_n;

  wdt_ctrl #(.INT_W(INT_W), .WIN(WIN), .DEF_INT(DEF_INT)) uCtrl (
    .clk(clk), .rst_n(sysRst_n), .wrEn(wrEn), .wrData(wrData),
    .strobe(strobe), .interval(interval), .lockState(lockState)
  );

  wdt_dpath #(.INT_W(INT_W), .BASE_LOG4(BASE_LOG4)) uDpath (
    .clk(clk), .rst_n(sysRst_n), .porRst_n(porRst_n), .strobe(strobe),
    .interval(interval), .rstReq(rstReq), .wdtFlag(wdtFlag)
  );

  always_comb begin
    rdData                = '0;
    rdData[STATUS_BIT]    = strobe.run;
    rdData[INT_W-1:0]     = interval;
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       porRst_n,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       rstReq,
  input logic       wdtFlag,
  input logic       lockState
);
  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !porRst_n)
    rstReq |=> !rstReq);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !porRst_n)
    rstReq |-> wdtFlag);

  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (!porRst_n)
    wdtFlag |=> wdtFlag);

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !porRst_n)
    lockState |=> lockState);

  // R4
  lock_run_chk: assert property (@(posedge clk) disable iff (!rst_n || !porRst_n)
    (lockState && rdData[4]) |=> rdData[4]);

  // R5
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n || !porRst_n)
    (wrEn && wrData[7]) |=> (rdData[2:0] == $past(rdData[2:0])));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !porRst_n)
    !rdData[4] |=> !rstReq);

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n || !porRst_n)
    (wrEn && wrData == 8'hA5) |=> (rdData[4] && !rstReq));

  // R6
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !porRst_n)
    (rdData[7:5] == 3'b000) && !rdData[3]);
endmodule

bind keyed_watchdog wdt_checker uChk (
  .clk(clk), .rst_n(rst_n), .porRst_n(porRst_n), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .rstReq(rstReq), .wdtFlag(wdtFlag), .lockState(lockState)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] d;
    logic [7:0] exp;
  } vec_t;

  // write, then expected read value one clock later (R3, R5, R6)
  localparam vec_t VECS [10] = '{
    '{8'h02, 8'h12}, '{8'h85, 8'h12}, '{8'h00, 8'h10}, '{8'hA5, 8'h10},
    '{8'hDE, 8'h10}, '{8'hAD, 8'h00}, '{8'h05, 8'h05}, '{8'hA5, 8'h15},
    '{8'h80, 8'h15}, '{8'h00, 8'h10}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       porRst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rstReq;
  logic       wdtFlag;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  keyed_watchdog dut (
    .clk(clk), .rst_n(rst_n), .porRst_n(porRst_n), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .rstReq(rstReq), .wdtFlag(wdtFlag)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called right after the reload write has been taken
  task automatic expectPeriod(input string tag, input int period);
    idle(period - 1);
    check({tag, " before"}, {7'b0, rstReq}, 8'h00);
    idle(1);
    check({tag, " at"}, {7'b0, rstReq}, 8'h01);
    check("R9 flag set", {7'b0, wdtFlag}, 8'h01);
    idle(1);
    check("R7 one clock", {7'b0, rstReq}, 8'h00);
  endtask

  initial begin
    idle(3);
    porRst_n = 1'b1;
    rst_n = 1'b1;
    idle(1);
    check("R1 read", rdData, 8'h17);
    check("R1 req", {7'b0, rstReq}, 8'h00);
    check("R9 no flag", {7'b0, wdtFlag}, 8'h00);

    for (int i = 0; i < 10; i++) begin
      wr(VECS[i].d);
      check("R5 vector", rdData, VECS[i].exp);
    end

    wr(8'hA5);
    expectPeriod("R2 int0", 64);
    idle(62);
    check("R7 repeat before", {7'b0, rstReq}, 8'h00);
    idle(1);
    check("R7 repeat at", {7'b0, rstReq}, 8'h01);

    wr(8'hA5);
    idle(40);
    wr(8'hA5);
    expectPeriod("R2 reload", 64);

    wr(8'h01);
    wr(8'hA5);
    expectPeriod("R2 int1", 256);

    wr(8'hDE);
    idle(4);
    wr(8'hAD);
    check("R3 late key", rdData, 8'h11);
    wr(8'hDE);
    idle(3);
    wr(8'hAD);
    check("R3 in window", rdData, 8'h01);

    begin
      int seen = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (rstReq) seen++;
      end
      check("R8 stopped", 8'(seen), 8'h00);
    end

    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    check("R1 after rst", rdData, 8'h17);
    check("R9 survives rst", {7'b0, wdtFlag}, 8'h01);

    wr(8'h00);
    wr(8'hFF);
    wr(8'hDE);
    wr(8'hAD);
    check("R4 locked", rdData, 8'h10);
    wr(8'hA5);
    expectPeriod("R4 reload", 64);

    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    wr(8'hDE);
    wr(8'hAD);
    check("R4 unlock by reset", rdData, 8'h07);

    porRst_n = 1'b0;
    idle(2);
    porRst_n = 1'b1;
    idle(1);
    check("R9 por clears", {7'b0, wdtFlag}, 8'h00);
    check("R1 after por", rdData, 8'h17);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule